// File: doc/BRIEF.md
# Shadow Stack Push and Pop-Check Unit

This unit carries out the two shadow-stack operations on behalf of an execution pipeline. A **push** writes a return address into memory one machine word below the current shadow stack pointer. The pointer moves down to that address once the memory side confirms the write. A **pop-check** reads the word at the current pointer and compares it with the link value the pipeline supplies. If they match, the pointer moves up by one word. If they differ, a software-check fault is reported and the pointer stays where it was.

The machine word is either 32 or 64 bits, chosen per operation. Each memory request is marked with a shadow-stack attribute, so the memory system can apply the permissions of shadow-stack pages.

Operations arrive on a valid/ready port. `op_ready` is high only while the unit is idle, so at most one operation and at most one memory access are ever in flight. The memory request is also valid/ready. Once `mem_req_valid` is raised, it stays high, with address, data, direction and size unchanged, until `mem_req_ready` is seen. The response side takes a response only while `mem_rsp_ready` is high.

Completion is a one-cycle `done` pulse, qualified by `fault_valid` and `fault_cause`. The pointer can be preloaded through `ssp_ld` while the unit is idle.

Top module: `sstk_unit`

## Requirements
- R1: A push issues one write request. Its address is the pointer minus 8 when `op_wide`=1 and minus 4 when `op_wide`=0. `mem_req_wide` equals `op_wide`. The write data is the source value in 64-bit mode, and its low 32 bits zero-extended in 32-bit mode.
- R2: The pointer keeps its old value until an error-free push response is accepted. After that response it holds the push address.
- R3: A pop-check issues one read request at the current pointer address, with `mem_req_write`=0 and `mem_req_wide` equal to `op_wide`.
- R4: If the loaded word equals the source value, the pointer increases by 8 (64-bit) or 4 (32-bit), and `done` comes without a fault.
- R5: If the loaded word differs from the source value, `done` comes with `fault_valid`=1 and `fault_cause`=1 (software check), and the pointer is unchanged. In 32-bit mode only the low 32 bits of the loaded word and of the source value are compared.
- R6: Every memory request has `mem_req_sstk`=1.
- R7: An operation accepted with `en`=0 issues no memory request, leaves the pointer unchanged, and completes with `done` and no fault.
- R8: A response with `mem_rsp_err`=1 ends the operation with `fault_cause`=2 (memory fault) and `fault_valid`=1, and leaves the pointer unchanged.
- R9: While busy, `op_ready` is 0. A memory request that is not yet accepted stays valid and stable.
- R10: After reset the pointer is 0, the unit is idle with `op_ready`=1, and `mem_req_valid` and `done` are 0.
- R11: `ssp_ld` loads `ssp_ld_val` into the pointer only while the unit is idle. It is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Shadow stack enabled; sampled when an operation is accepted |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Unit can accept an operation |
| op_pop | input | 1 | 1 = pop-check, 0 = push |
| op_wide | input | 1 | 1 = 64-bit word, 0 = 32-bit word |
| op_src | input | 64 | Link value: stored by a push, compared by a pop-check |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_valid | output | 1 | Completion carries a fault |
| fault_cause | output | 2 | 0 none, 1 software check, 2 memory fault |
| ssp_ld | input | 1 | Pointer preload strobe (honoured when idle) |
| ssp_ld_val | input | AW | Pointer preload value |
| ssp | output | AW | Current shadow stack pointer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_wide | output | 1 | 1 = 64-bit access, 0 = 32-bit |
| mem_req_sstk | output | 1 | Shadow-stack access attribute |
| mem_req_addr | output | AW | Access address |
| mem_req_wdata | output | 64 | Store data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Unit is waiting for a response |
| mem_rsp_err | input | 1 | Access faulted |
| mem_rsp_rdata | input | 64 | Load data |

## Verification
The hardest situation to reach is a pointer preload arriving while a push is stalled. The stall comes from back-pressure on the memory request, and the pointer must still end at the push address, not at the preloaded value. The stimulus holds `mem_req_ready` low for several cycles and pulses `ssp_ld` inside that window.

A second difficult case is a 32-bit pop-check where the loaded word differs only in its upper half. The bench returns such a word to show that the upper half does not take part in the comparison.

// File: rtl/sstk_pkg.sv
package sstk_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned LANE_W = 32;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_RSP  = 2'd2,
    S_FIN  = 2'd3
  } sstk_state_e;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_SWCHECK = 2'd1,
    FC_MEMERR  = 2'd2
  } sstk_fault_e;

  typedef struct packed {
    logic              pop;
    logic              wide;
    logic [WORD_W-1:0] src;
  } sstk_op_t;
endpackage

// File: rtl/sstk_ctrl.sv
module sstk_ctrl
  import sstk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic        en,
  input  logic        req_ready,
  input  logic        rsp_valid,
  output sstk_state_e state,
  output logic        accept,
  output logic        req_fire,
  output logic        rsp_fire
);
  sstk_state_e nxt;

  assign accept   = (state == S_IDLE) && op_valid;
  assign req_fire = (state == S_REQ) && req_ready;
  assign rsp_fire = (state == S_RSP) && rsp_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: if (op_valid) nxt = en ? S_REQ : S_FIN;
      S_REQ:  if (req_ready) nxt = S_RSP;
      S_RSP:  if (rsp_valid) nxt = S_FIN;
      S_FIN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sstk_ptr.sv
module sstk_ptr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          commit,
  input  logic          commit_up,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_dn
);
  localparam logic [AW-1:0] STEP_W = AW'(8);
  localparam logic [AW-1:0] STEP_N = AW'(4);

  logic [AW-1:0] step;
  logic [AW-1:0] ptr_up;

  assign step   = wide ? STEP_W : STEP_N;
  assign ptr_dn = ptr - step;
  assign ptr_up = ptr + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (commit) ptr <= commit_up ? ptr_up : ptr_dn;
    else if (ld)     ptr <= ld_val;
  end
endmodule

// File: rtl/sstk_cmp.sv
module sstk_cmp #(
  parameter int unsigned WW = 64,
  parameter int unsigned LW = 32
) (
  input  logic [WW-1:0] a,
  input  logic [WW-1:0] b,
  input  logic          wide,
  output logic          mismatch
);
  localparam int unsigned NL = WW / LW;

  logic [NL-1:0] lane_diff;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic differ;
    assign differ = (a[g*LW +: LW] != b[g*LW +: LW]);
    if (g == 0) begin : g_base
      assign lane_diff[g] = differ;
    end else begin : g_upper
      assign lane_diff[g] = differ && wide;
    end
  end

  assign mismatch = |lane_diff;
endmodule

// File: rtl/sstk_unit.sv
module sstk_unit
  import sstk_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_pop,
  input  logic              op_wide,
  input  logic [63:0]       op_src,
  output logic              busy,
  output logic              done,
  output logic              fault_valid,
  output logic [1:0]        fault_cause,
  input  logic              ssp_ld,
  input  logic [AW-1:0]     ssp_ld_val,
  output logic [AW-1:0]     ssp,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic              mem_req_wide,
  output logic              mem_req_sstk,
  output logic [AW-1:0]     mem_req_addr,
  output logic [63:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic              mem_rsp_err,
  input  logic [63:0]       mem_rsp_rdata
);
  localparam logic [WORD_W-1:0] LOW_MASK = {{(WORD_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

  sstk_state_e state;
  logic        accept, req_fire, rsp_fire;
  sstk_op_t    op_q;
  sstk_fault_e cause_q;
  logic        mismatch;
  logic        commit;
  logic [AW-1:0] ptr_dn;

  sstk_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .en       (en),
    .req_ready(mem_req_ready),
    .rsp_valid(mem_rsp_valid),
    .state    (state),
    .accept   (accept),
    .req_fire (req_fire),
    .rsp_fire (rsp_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
    end else if (accept) begin
      op_q.pop  <= op_pop;
      op_q.wide <= op_wide;
      op_q.src  <= op_wide ? op_src : (op_src & LOW_MASK);
    end
  end

  sstk_cmp #(.WW(WORD_W), .LW(LANE_W)) u_cmp (
    .a       (op_q.src),
    .b       (mem_rsp_rdata),
    .wide    (op_q.wide),
    .mismatch(mismatch)
  );

  assign commit = rsp_fire && !mem_rsp_err && (!op_q.pop || !mismatch);

  sstk_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (op_q.wide),
    .ld       (ssp_ld && (state == S_IDLE)),
    .ld_val   (ssp_ld_val),
    .commit   (commit),
    .commit_up(op_q.pop),
    .ptr      (ssp),
    .ptr_dn   (ptr_dn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= FC_NONE;
    end else if (accept) begin
      cause_q <= FC_NONE;
    end else if (rsp_fire) begin
      if (mem_rsp_err)                cause_q <= FC_MEMERR;
      else if (op_q.pop && mismatch)  cause_q <= FC_SWCHECK;
      else                            cause_q <= FC_NONE;
    end
  end

  assign op_ready      = (state == S_IDLE);
  assign busy          = (state != S_IDLE);
  assign done          = (state == S_FIN);
  assign fault_valid   = done && (cause_q != FC_NONE);
  assign fault_cause   = done ? cause_q : FC_NONE;

  assign mem_req_valid = (state == S_REQ);
  assign mem_req_write = !op_q.pop;
  assign mem_req_wide  = op_q.wide;
  assign mem_req_sstk  = 1'b1;
  assign mem_req_addr  = op_q.pop ? ssp : ptr_dn;
  assign mem_req_wdata = op_q.src;
  assign mem_rsp_ready = (state == S_RSP);
endmodule

// File: rtl/sstk_unit_chk.sv
module sstk_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_ready,
  input logic          busy,
  input logic          done,
  input logic          fault_valid,
  input logic [AW-1:0] ssp,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic          mem_req_wide,
  input logic          mem_req_sstk,
  input logic [AW-1:0] mem_req_addr,
  input logic [63:0]   mem_req_wdata,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_ready,
  input logic          mem_rsp_err
);
  assert_sstk_attr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_sstk);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata) && $stable(mem_req_wide));

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_ready);

  assert_push_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |->
      mem_req_addr == ssp - (mem_req_wide ? AW'(8) : AW'(4)));

  assert_pop_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> mem_req_addr == ssp);

  assert_ptr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> $stable(ssp));

  assert_err_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_ready && mem_rsp_err |=> $stable(ssp));

  assert_fault_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> done);
endmodule

bind sstk_unit sstk_unit_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_ready     (op_ready),
  .busy         (busy),
  .done         (done),
  .fault_valid  (fault_valid),
  .ssp          (ssp),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_wide (mem_req_wide),
  .mem_req_sstk (mem_req_sstk),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_ready(mem_rsp_ready),
  .mem_rsp_err  (mem_rsp_err)
);

// File: tb/sstk_unit_tb.sv
module sstk_unit_tb;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic          op_pop = 1'b0;
  logic          op_wide = 1'b0;
  logic [63:0]   op_src = '0;
  logic          busy, done, fault_valid;
  logic [1:0]    fault_cause;
  logic          ssp_ld = 1'b0;
  logic [AW-1:0] ssp_ld_val = '0;
  logic [AW-1:0] ssp;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_write, mem_req_wide, mem_req_sstk;
  logic [AW-1:0] mem_req_addr;
  logic [63:0]   mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic          mem_rsp_ready;
  logic          mem_rsp_err = 1'b0;
  logic [63:0]   mem_rsp_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic finished = 1'b0;
  logic [AW-1:0] m_ssp = '0;

  always #2 clk = ~clk;

  sstk_unit #(.AW(AW)) u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic pop, input logic wide, input logic [63:0] src,
                        input logic en_i, input logic [63:0] rdata, input logic err,
                        input int bp, input int lat, input logic ld_busy);
    logic [AW-1:0] step;
    logic [AW-1:0] exp_addr, exp_ssp;
    logic [63:0]   mask;
    logic          match;
    logic [1:0]    exp_fc;
    step     = wide ? AW'(8) : AW'(4);
    mask     = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    exp_addr = pop ? m_ssp : m_ssp - step;
    match    = ((rdata ^ src) & mask) == 64'd0;
    if (!en_i)      begin exp_fc = 2'd0; exp_ssp = m_ssp;        end
    else if (err)   begin exp_fc = 2'd2; exp_ssp = m_ssp;        end
    else if (!pop)  begin exp_fc = 2'd0; exp_ssp = m_ssp - step; end
    else if (match) begin exp_fc = 2'd0; exp_ssp = m_ssp + step; end
    else            begin exp_fc = 2'd1; exp_ssp = m_ssp;        end

    @(negedge clk);
    check("R9 op_ready idle", 64'(op_ready), 64'd1);
    en = en_i; op_pop = pop; op_wide = wide; op_src = src; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    if (en_i) begin
      check("R9 op_ready low while busy", 64'(op_ready), 64'd0);
      for (int k = 0; k < bp; k++) begin
        check("R9 request held", 64'(mem_req_valid), 64'd1);
        if (ld_busy && k == 0) begin ssp_ld = 1'b1; ssp_ld_val = 32'h5555_0000; end
        @(negedge clk);
        ssp_ld = 1'b0;
      end
      check("R9 request valid", 64'(mem_req_valid), 64'd1);
      check("R6 sstk attribute", 64'(mem_req_sstk), 64'd1);
      check(pop ? "R3 address" : "R1 address", 64'(mem_req_addr), 64'(exp_addr));
      check(pop ? "R3 direction" : "R1 direction", 64'(mem_req_write), 64'(!pop));
      check(pop ? "R3 size" : "R1 size", 64'(mem_req_wide), 64'(wide));
      if (!pop) check("R1 write data", mem_req_wdata, src & mask);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      check("R2 pointer held until response", 64'(ssp), 64'(m_ssp));
      repeat (lat) @(negedge clk);
      check("R9 response ready", 64'(mem_rsp_ready), 64'd1);
      mem_rsp_valid = 1'b1; mem_rsp_err = err; mem_rsp_rdata = rdata;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    end else begin
      check("R7 no request when disabled", 64'(mem_req_valid), 64'd0);
    end
    check("R4 R5 R7 R8 done pulse", 64'(done), 64'd1);
    check("R5 R8 fault cause", 64'(fault_cause), 64'(exp_fc));
    check("R5 R8 fault valid", 64'(fault_valid), 64'(exp_fc != 2'd0));
    check("R2 R4 R5 R7 R8 R11 pointer", 64'(ssp), 64'(exp_ssp));
    m_ssp = exp_ssp;
    @(negedge clk);
    check("R9 idle after done", 64'(op_ready), 64'd1);
    check("R4 done is one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 pointer", 64'(ssp), 64'd0);
    check("R10 op_ready", 64'(op_ready), 64'd1);
    check("R10 no request", 64'(mem_req_valid), 64'd0);
    check("R10 no done", 64'(done), 64'd0);
    m_ssp = '0;
  endtask

  task automatic t_load_idle();
    @(negedge clk);
    ssp_ld = 1'b1; ssp_ld_val = 32'h0000_1000;
    @(negedge clk);
    ssp_ld = 1'b0;
    check("R11 load while idle", 64'(ssp), 64'h1000);
    m_ssp = 32'h0000_1000;
  endtask

  task automatic t_push64();
    run_op(1'b0, 1'b1, 64'h1122_3344_5566_7788, 1'b1, '0, 1'b0, 2, 1, 1'b0);
  endtask

  task automatic t_push32();
    run_op(1'b0, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, '0, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic t_pop32_upper_differs();
    run_op(1'b1, 1'b0, 64'h0000_0000_CCCC_DDDD, 1'b1, 64'hDEAD_0000_CCCC_DDDD, 1'b0, 1, 2, 1'b0);
  endtask

  task automatic t_pop64_mismatch();
    run_op(1'b1, 1'b1, 64'h1122_3344_5566_7788, 1'b1, 64'h1122_3344_5566_7789, 1'b0, 0, 1, 1'b0);
  endtask

  task automatic t_pop64_match();
    run_op(1'b1, 1'b1, 64'h1122_3344_5566_7788, 1'b1, 64'h1122_3344_5566_7788, 1'b0, 3, 0, 1'b0);
  endtask

  task automatic t_mem_errors();
    run_op(1'b0, 1'b1, 64'h0BAD_0BAD_0BAD_0BAD, 1'b1, '0, 1'b1, 1, 1, 1'b0);
    run_op(1'b1, 1'b0, 64'h0000_0000_1234_5678, 1'b1, 64'h1234_5678, 1'b1, 0, 0, 1'b0);
  endtask

  task automatic t_disabled();
    run_op(1'b0, 1'b1, 64'hFFFF_0000_FFFF_0000, 1'b0, '0, 1'b0, 0, 0, 1'b0);
    run_op(1'b1, 1'b0, 64'h0000_0000_0000_0001, 1'b0, '0, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic t_load_while_busy();
    run_op(1'b0, 1'b1, 64'h0101_0202_0303_0404, 1'b1, '0, 1'b0, 3, 1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_load_idle();
    t_push64();
    t_push32();
    t_pop32_upper_differs();
    t_pop64_mismatch();
    t_pop64_match();
    t_mem_errors();
    t_disabled();
    t_load_while_busy();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule